// File: doc/BRIEF.md
# Two-Wire Identification Store Slave

This block is the target side of a two-wire serial bus that holds a small identification table: 256 bytes of configuration data that a host reads at power-up to learn what is fitted on a board. The host drives the clock line, and the data line is shared open-drain. The block watches both lines through synchronizers on its own system clock. It pulls the data line low only when its enable output is high.

A host opens a transfer with a start condition and then sends a 7-bit device address plus a direction bit. For a write, a word-address byte loads the internal pointer and any further bytes are stored at successive locations. For a read, bytes stream out from the pointer for as long as the host acknowledges. A repeated start after the word address turns a write into a random read. A stop that ends a transfer which stored data opens an internal write window. For a set number of clock cycles the block then ignores its own address. On reset, the table is loaded from a formula set by parameters, and one byte carries a checksum.

Top module: `eep_presence_slave`

## Requirements
- R1: Until a start condition is seen (data falling while clock is high), all clock and data activity is ignored and the data line is never pulled low.
- R2: A stop condition (data rising while clock is high) ends any transfer, releases the data line, and returns the slave to idle. The line is also released out of reset.
- R3: The slave changes its data-line drive only while the clock line is low.
- R4: The device address is the seven bits 1,0,1,0,0,0,strap, sent MSB first, followed by a direction bit (0 write, 1 read). On a match the slave pulls data low during the ninth clock. On any other address it sends no acknowledge and stays silent until the next start or stop.
- R5: In a write, the first byte after the address loads the word pointer. Each later byte is acknowledged, stored at the pointer, and advances the pointer by one.
- R6: In a read, the byte at the pointer is sent MSB first and the pointer then advances. Another byte follows whenever the host acknowledges the ninth clock. Without that acknowledge, the slave releases the line and stays silent until a start or stop.
- R7: The word pointer wraps from 255 to 0, for both writes and reads.
- R8: After a stop that ends a transfer in which at least one data byte was stored, the slave does not acknowledge its address for WRITE_CYCLES clock cycles and keeps the line released. A stop after a transfer that stored nothing starts no such window.
- R9: After reset, byte i holds (i*INIT_MUL + INIT_ADD) mod 256 for every i other than SUM_IDX. Byte SUM_IDX (63 by default) holds the sum, mod 256, of bytes 0 to SUM_IDX-1. The pointer resets to 0.
- R10: The strap input selects between two addresses, and only the selected one is acknowledged.
- R11: A start in the middle of a transfer re-addresses the slave and keeps the pointer, so a write of the word address followed by a repeated start gives a read from that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset; reloads the table |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_i | input | 1 | Address strap, least significant address bit |
| sda_oe_o | output | 1 | High to pull the data line low |

## Verification
Most faults in the control state show up at the data line within one byte time. A lost bit count or a wrong phase gives a missing or misplaced acknowledge on the ninth clock, or data shifted by one bit. A pointer that steps wrongly, or that fails to wrap, returns a wrong byte on the next read-back, so every write is followed by a read of the same locations. A write window that starts too early, starts too late, or never starts shows at the next address byte as a wrong acknowledge. The bench probes that window both right after a stop and after it has expired.

// File: rtl/eep_pkg.sv
package eep_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK,
      ST_HOLD
   } eep_state_e;

   typedef enum logic [1:0] {
      PH_DEV,
      PH_WORD,
      PH_DATA
   } eep_phase_e;

   // Power-up value of one table entry; the entry at sum_idx is the
   // modulo-256 sum of all entries below it.
   function automatic logic [BYTE_W-1:0] seed_byte(input int idx,
                                                   input logic [BYTE_W-1:0] mul,
                                                   input logic [BYTE_W-1:0] add,
                                                   input int sum_idx);
      logic [BYTE_W-1:0] acc;
      acc = '0;
      if (idx != sum_idx) begin
         acc = BYTE_W'(idx * int'(mul) + int'(add));
      end else begin
         for (int j = 0; j < sum_idx; j++) begin
            acc = acc + BYTE_W'(j * int'(mul) + int'(add));
         end
      end
      return acc;
   endfunction

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         last  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], line_i};
         last  <= chain[STAGES-1];
      end
   end

   assign level_o = chain[STAGES-1];
   assign rise_o  = chain[STAGES-1] & ~last;
   assign fall_o  = ~chain[STAGES-1] & last;
endmodule

// File: rtl/eep_store.sv
module eep_store #(
   parameter int         AW      = 8,
   parameter logic [7:0] MUL     = 8'd29,
   parameter logic [7:0] ADD     = 8'd11,
   parameter int         SUM_IDX = 63
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [7:0]    wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [7:0]    rdata_o
);
   localparam int DEPTH = 1 << AW;

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) begin
            cells[k] <= eep_pkg::seed_byte(k, MUL, ADD, SUM_IDX);
         end
      end else if (we_i) begin
         cells[waddr_i] <= wdata_i;
      end
   end

   assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/eep_write_timer.sv
module eep_write_timer #(
   parameter int CYCLES = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   localparam int CNT_W = $clog2(CYCLES + 1);

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (start_i) begin
         remain <= CNT_W'(CYCLES);
      end else if (remain != '0) begin
         remain <= remain - 1'b1;
      end
   end

   assign busy_o = (remain != '0);
endmodule

// File: rtl/eep_proto.sv
module eep_proto
   import eep_pkg::*;
#(
   parameter int         AW       = 8,
   parameter logic [3:0] DEV_TYPE = 4'b1010
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_lvl_i,
   input  logic          scl_rise_i,
   input  logic          scl_fall_i,
   input  logic          sda_lvl_i,
   input  logic          sda_rise_i,
   input  logic          sda_fall_i,
   input  logic          strap_i,
   input  logic          busy_i,
   input  logic [7:0]    rdata_i,
   output logic [AW-1:0] ptr_o,
   output logic          we_o,
   output logic [AW-1:0] waddr_o,
   output logic [7:0]    wdata_o,
   output logic          commit_o,
   output logic          stop_o,
   output logic          hold_o,
   output logic          sda_oe_o
);
   eep_state_e state;
   eep_phase_e phase;
   logic [3:0] cnt;
   logic [7:0] shreg;
   logic [6:0] txreg;
   logic       rd_mode;
   logic       wrote;
   logic       mack;

   logic start_c, stop_c, dev_hit;
   assign start_c = sda_fall_i & scl_lvl_i;
   assign stop_c  = sda_rise_i & scl_lvl_i;
   assign dev_hit = (shreg[7:1] == {DEV_TYPE, 2'b00, strap_i}) & ~busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         phase    <= PH_DEV;
         cnt      <= '0;
         shreg    <= '0;
         txreg    <= '0;
         rd_mode  <= 1'b0;
         wrote    <= 1'b0;
         mack     <= 1'b0;
         ptr_o    <= '0;
         we_o     <= 1'b0;
         waddr_o  <= '0;
         wdata_o  <= '0;
         commit_o <= 1'b0;
         sda_oe_o <= 1'b0;
      end else begin
         we_o     <= 1'b0;
         commit_o <= 1'b0;
         if (start_c) begin
            state    <= ST_RX;
            phase    <= PH_DEV;
            cnt      <= '0;
            sda_oe_o <= 1'b0;
         end else if (stop_c) begin
            state    <= ST_IDLE;
            sda_oe_o <= 1'b0;
            commit_o <= wrote;
            wrote    <= 1'b0;
         end else begin
            case (state)
               ST_RX: begin
                  if (scl_rise_i) begin
                     shreg <= {shreg[6:0], sda_lvl_i};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall_i && cnt == 4'd8) begin
                     case (phase)
                        PH_DEV: begin
                           if (dev_hit) begin
                              rd_mode  <= shreg[0];
                              phase    <= PH_WORD;
                              sda_oe_o <= 1'b1;
                              state    <= ST_ACK;
                           end else begin
                              state <= ST_HOLD;
                           end
                        end
                        PH_WORD: begin
                           ptr_o    <= shreg[AW-1:0];
                           phase    <= PH_DATA;
                           sda_oe_o <= 1'b1;
                           state    <= ST_ACK;
                        end
                        default: begin
                           we_o     <= 1'b1;
                           waddr_o  <= ptr_o;
                           wdata_o  <= shreg;
                           ptr_o    <= ptr_o + 1'b1;
                           wrote    <= 1'b1;
                           sda_oe_o <= 1'b1;
                           state    <= ST_ACK;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall_i) begin
                     cnt <= '0;
                     if (rd_mode) begin
                        state    <= ST_TX;
                        txreg    <= rdata_i[6:0];
                        sda_oe_o <= ~rdata_i[7];
                     end else begin
                        state    <= ST_RX;
                        sda_oe_o <= 1'b0;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise_i) begin
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall_i) begin
                     if (cnt == 4'd8) begin
                        sda_oe_o <= 1'b0;
                        ptr_o    <= ptr_o + 1'b1;
                        state    <= ST_MACK;
                     end else begin
                        sda_oe_o <= ~txreg[6];
                        txreg    <= {txreg[5:0], 1'b0};
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise_i) begin
                     mack <= ~sda_lvl_i;
                  end else if (scl_fall_i) begin
                     if (mack) begin
                        state    <= ST_TX;
                        cnt      <= '0;
                        txreg    <= rdata_i[6:0];
                        sda_oe_o <= ~rdata_i[7];
                     end else begin
                        state <= ST_HOLD;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign stop_o = stop_c;
   assign hold_o = (state == ST_HOLD);
endmodule

// File: rtl/eep_presence_slave.sv
module eep_presence_slave #(
   parameter int         ADDR_W       = 8,
   parameter int         SYNC_STAGES  = 2,
   parameter int         WRITE_CYCLES = 500000,
   parameter logic [3:0] DEV_TYPE     = 4'b1010,
   parameter logic [7:0] INIT_MUL     = 8'd29,
   parameter logic [7:0] INIT_ADD     = 8'd11,
   parameter int         SUM_IDX      = 63
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic strap_i,
   output logic sda_oe_o
);
   localparam int DEPTH = 1 << ADDR_W;

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= eep_pkg::BYTE_W)
         else $error("ADDR_W must lie in 1..8");
      assert (SYNC_STAGES >= 2)
         else $error("SYNC_STAGES must be at least 2");
      assert (SUM_IDX >= 0 && SUM_IDX < DEPTH)
         else $error("SUM_IDX must index the table");
      assert (WRITE_CYCLES >= 0)
         else $error("WRITE_CYCLES must not be negative");
   end

   logic [1:0] raw_line, lvl, rise, fall;
   assign raw_line = {sda_i, scl_i};

   for (genvar g = 0; g < 2; g++) begin : g_sync
      eep_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .line_i  (raw_line[g]),
         .level_o (lvl[g]),
         .rise_o  (rise[g]),
         .fall_o  (fall[g])
      );
   end

   logic [ADDR_W-1:0] ptr, waddr;
   logic [7:0]        wdata, rdata;
   logic              we, commit, busy, stop_seen, in_hold;

   eep_proto #(.AW(ADDR_W), .DEV_TYPE(DEV_TYPE)) i_proto (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_lvl_i  (lvl[0]),
      .scl_rise_i (rise[0]),
      .scl_fall_i (fall[0]),
      .sda_lvl_i  (lvl[1]),
      .sda_rise_i (rise[1]),
      .sda_fall_i (fall[1]),
      .strap_i    (strap_i),
      .busy_i     (busy),
      .rdata_i    (rdata),
      .ptr_o      (ptr),
      .we_o       (we),
      .waddr_o    (waddr),
      .wdata_o    (wdata),
      .commit_o   (commit),
      .stop_o     (stop_seen),
      .hold_o     (in_hold),
      .sda_oe_o   (sda_oe_o)
   );

   eep_store #(.AW(ADDR_W), .MUL(INIT_MUL), .ADD(INIT_ADD), .SUM_IDX(SUM_IDX)) i_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (we),
      .waddr_i (waddr),
      .wdata_i (wdata),
      .raddr_i (ptr),
      .rdata_o (rdata)
   );

   if (WRITE_CYCLES == 0) begin : g_no_timer
      assign busy = 1'b0;
   end else begin : g_timer
      eep_write_timer #(.CYCLES(WRITE_CYCLES)) i_timer (
         .clk     (clk),
         .rst_n   (rst_n),
         .start_i (commit),
         .busy_o  (busy)
      );
   end
endmodule

// File: rtl/eep_presence_checker.sv
module eep_presence_checker (
   input logic clk,
   input logic rst_n,
   input logic scl_lvl,
   input logic stop_seen,
   input logic busy,
   input logic in_hold,
   input logic sda_oe
);
   AST_RELEASE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      stop_seen |=> !sda_oe) else $error("drive kept after stop"); // R2

   AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_lvl) else $error("drive changed with clock high"); // R3

   AST_QUIET_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_oe) else $error("line driven in write window"); // R8

   AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_seen, 2)) else $error("write window without stop"); // R8

   AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      in_hold |-> !sda_oe) else $error("line driven while waiting"); // R6
endmodule

bind eep_presence_slave eep_presence_checker i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_lvl   (lvl[0]),
   .stop_seen (stop_seen),
   .busy      (busy),
   .in_hold   (in_hold),
   .sda_oe    (sda_oe_o)
);

// File: tb/test_eep_presence_slave.sv
module test_eep_presence_slave;
   localparam int Q     = 10;
   localparam int WCYC  = 2000;
   localparam int WD    = 180000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic strap = 1'b0;
   logic sda_oe;
   logic sda_w;

   int n_chk = 0;
   int n_bad = 0;
   int r3_bad = 0;
   logic prev_oe = 1'b0;
   bit done = 1'b0;

   logic [7:0] exp_mem [256];
   logic [7:0] exp_ptr;

   always #10 clk = ~clk;

   assign sda_w = sda_m & ~sda_oe;

   eep_presence_slave #(.WRITE_CYCLES(WCYC)) i_eep_presence_slave (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_m),
      .sda_i    (sda_w),
      .strap_i  (strap),
      .sda_oe_o (sda_oe)
   );

   // R3 monitor: drive must not change while the wire clock is high
   always @(negedge clk) begin
      if (rst_n && scl_m && (sda_oe !== prev_oe)) r3_bad++;
      prev_oe = sda_oe;
   end

   function automatic logic [7:0] init_val(input int i);
      logic [7:0] s;
      s = '0;
      if (i != 63) return 8'(i * 29 + 11);
      for (int j = 0; j < 63; j++) s = s + 8'(j * 29 + 11);
      return s;
   endfunction

   task automatic expect_eq(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic wq(input int n);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic bus_start();
      scl_m = 1'b0; wq(1);
      sda_m = 1'b1; wq(1);
      scl_m = 1'b1; wq(2);
      sda_m = 1'b0; wq(2);
      scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      scl_m = 1'b0; wq(1);
      sda_m = 1'b0; wq(1);
      scl_m = 1'b1; wq(2);
      sda_m = 1'b1; wq(2);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         wq(1); sda_m = b[i];
         wq(1); scl_m = 1'b1;
         wq(2); scl_m = 1'b0;
      end
      wq(1); sda_m = 1'b1;
      wq(1); scl_m = 1'b1;
      wq(1); ack = ~sda_w;
      wq(1); scl_m = 1'b0;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         wq(1); sda_m = 1'b1;
         wq(1); scl_m = 1'b1;
         wq(1); b[i] = sda_w;
         wq(1); scl_m = 1'b0;
      end
      wq(1); sda_m = ~give_ack;
      wq(1); scl_m = 1'b1;
      wq(2); scl_m = 1'b0;
   endtask

   task automatic write_block(input logic [7:0] addr, input int n, input logic [7:0] d [4]);
      logic ack;
      bus_start();
      send_byte(8'hA0, ack); expect_eq("R4 write address ack", ack, 1);
      send_byte(addr, ack);  expect_eq("R5 word address ack", ack, 1);
      exp_ptr = addr;
      for (int k = 0; k < n; k++) begin
         send_byte(d[k], ack); expect_eq("R5 data byte ack", ack, 1);
         exp_mem[exp_ptr] = d[k];
         exp_ptr = exp_ptr + 8'd1;
      end
      bus_stop();
   endtask

   task automatic random_read(input logic [7:0] addr, input int n, input string tag);
      logic ack;
      logic [7:0] b;
      bus_start();
      send_byte(8'hA0, ack); expect_eq("R4 address ack", ack, 1);
      send_byte(addr, ack);  expect_eq("R5 pointer load ack", ack, 1);
      bus_start();
      send_byte(8'hA1, ack); expect_eq("R11 repeated start ack", ack, 1);
      exp_ptr = addr;
      for (int k = 0; k < n; k++) begin
         recv_byte(k != n - 1, b);
         expect_eq(tag, b, exp_mem[exp_ptr]);
         exp_ptr = exp_ptr + 8'd1;
      end
      bus_stop();
   endtask

   initial begin
      repeat (WD) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic ack;
      logic [7:0] b;
      logic [7:0] d [4];
      logic all_high;

      void'($urandom(32'd2024));
      for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
      exp_ptr = 8'd0;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      expect_eq("R2 reset release", sda_oe, 0);

      // R1: a full address byte with no start before it
      scl_m = 1'b0;
      send_byte(8'hA1, ack);
      expect_eq("R1 no response before start", ack, 0);
      bus_stop();

      // R9: sequential read from reset pointer over the checksum entry
      bus_start();
      send_byte(8'hA1, ack); expect_eq("R4 read address ack", ack, 1);
      for (int k = 0; k < 64; k++) begin
         recv_byte(k != 63, b);
         expect_eq(k == 63 ? "R9 checksum byte" : "R9 initial byte", b, exp_mem[k]);
      end
      exp_ptr = 8'd64;
      bus_stop();

      // R4: wrong strap bit and wrong device type
      bus_start();
      send_byte(8'hA3, ack); expect_eq("R4 strap mismatch nack", ack, 0);
      bus_stop();
      bus_start();
      send_byte(8'hB1, ack); expect_eq("R4 type mismatch nack", ack, 0);
      bus_stop();

      // R10: strap high moves the address
      strap = 1'b1;
      bus_start();
      send_byte(8'hA3, ack); expect_eq("R10 strap address ack", ack, 1);
      recv_byte(1'b0, b);    expect_eq("R10 read after strap", b, exp_mem[64]);
      bus_stop();
      exp_ptr = 8'd65;
      bus_start();
      send_byte(8'hA1, ack); expect_eq("R10 old address nack", ack, 0);
      bus_stop();
      strap = 1'b0;

      // R6: continue on ack, release on missing ack
      bus_start();
      send_byte(8'hA1, ack); expect_eq("R6 address ack", ack, 1);
      recv_byte(1'b1, b);    expect_eq("R6 first byte", b, exp_mem[65]);
      recv_byte(1'b0, b);    expect_eq("R6 second byte", b, exp_mem[66]);
      all_high = 1'b1;
      recv_byte(1'b0, b);
      if (b != 8'hFF) all_high = 1'b0;
      expect_eq("R6 silent after nack", all_high, 1);
      bus_stop();
      exp_ptr = 8'd67;

      // R7 and R8: write across the top, probe the window
      d[0] = 8'h3C; d[1] = 8'hC3; d[2] = 8'h5A; d[3] = 8'h00;
      write_block(8'hFE, 3, d);
      bus_start();
      send_byte(8'hA0, ack); expect_eq("R8 deaf after write", ack, 0);
      bus_stop();
      repeat (WCYC + 100) @(negedge clk);
      random_read(8'hFE, 3, "R7 wrapped read-back");
      bus_start();
      send_byte(8'hA1, ack); expect_eq("R7 pointer wrapped", ack, 1);
      recv_byte(1'b0, b);    expect_eq("R7 byte after wrap", b, exp_mem[1]);
      bus_stop();

      // R8: a transfer that only sets the pointer starts no window
      bus_start();
      send_byte(8'hA0, ack); expect_eq("R4 address ack", ack, 1);
      send_byte(8'h10, ack); expect_eq("R5 word address ack", ack, 1);
      bus_stop();
      bus_start();
      send_byte(8'hA1, ack); expect_eq("R8 no window without data", ack, 1);
      recv_byte(1'b0, b);    expect_eq("R5 current address after load", b, exp_mem[16]);
      bus_stop();

      // random writes with read-back
      for (int r = 0; r < 6; r++) begin
         logic [7:0] a;
         int n;
         a = 8'($urandom % 256);
         n = 1 + int'($urandom % 3);
         for (int k = 0; k < 4; k++) d[k] = 8'($urandom);
         write_block(a, n, d);
         repeat (WCYC + 100) @(negedge clk);
         random_read(a, n, "R5 random read-back");
      end

      expect_eq("R3 drive changes with clock low", r3_bad, 0);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule